// File: doc/BRIEF.md
# Load-Use Interlock Detector

This block sits beside the decode stage of an in-order integer pipeline. Whenever a load issues, it looks at the instruction word that comes right after the load. It decides whether that instruction reads the register the load is about to write. If it does, the block raises a one-cycle stall pulse on the following clock. The pipeline control logic uses that pulse to hold the consumer for one cycle. The block also keeps a saturating count of every interlock it has flagged.

The decision depends only on fields of the following instruction word. The top two bits select its format. Branch, set-high and call words read no general register, so they never interlock. Floating-point operate words carry the tag 0x1A in bits [24:20], and their sources live in the floating-point file, so they are skipped as well. Every other arithmetic or memory word has its first source field compared. Its second source field is compared only when the word does not carry an immediate operand. Some kinds of load finish through a different path, and these never cause an interlock. Those kinds are doubleword, swap and test-and-set byte.

Top module: `load_use_interlock`

## Requirements
- R1: While `rst_n` is low at a rising edge, `stall` and `ilock_count` are cleared to zero on that edge, whatever the other inputs are.
- R2: A following word whose bits [31:30] are 00 (branch / set-high) or 01 (call) never produces a stall.
- R3: A following word with bits [31:30] = 10 and bits [24:20] = 5'h1A never produces a stall. Any other value of bits [24:20] in format 10 is checked as in R4 to R6.
- R4: For a following word in format 10 (not floating-point) or format 11, a stall is produced when `ld_dest` equals bits [18:14]. Bits [29:25] of the word are never compared.
- R5: When bit 13 of the following word is 1 and bits [18:14] differ from `ld_dest`, no stall is produced, even if bits [4:0] equal `ld_dest`.
- R6: When bit 13 is 0 and bits [18:14] differ from `ld_dest`, a stall is produced exactly when bits [4:0] equal `ld_dest`.
- R7: `ld_kind` encodes the load as 0 word, 1 unsigned byte, 2 unsigned half, 3 signed byte, 4 signed half, 5 doubleword, 6 swap, 7 test-and-set byte. Only codes 0 to 4 can produce a stall.
- R8: `stall` is registered. It is 1 in exactly the cycle after an edge where `ld_valid` was 1 and the rules above found a match. It is 0 otherwise, including after an edge where `ld_valid` was 0.
- R9: `ilock_count` increases by one on the same edge that sets `stall`. It holds otherwise. It saturates at all ones (width `CNT_W`, default 32).
- R10: Register number 0 gets no special treatment. A load to register 0 interlocks like any other destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_valid | input | 1 | A load issues this cycle |
| ld_kind | input | 3 | Kind of the issuing load (encoding in R7) |
| ld_dest | input | 5 | Destination register of the load |
| next_insn | input | 32 | Instruction word following the load |
| stall | output | 1 | One-cycle load-use stall pulse |
| ilock_count | output | CNT_W | Saturating count of detected interlocks |

## Verification
The bench targets the second source field when an immediate is present. A design that ignores bit 13 would stall on immediates whose low bits happen to equal the destination. It also probes the floating-point tag against its neighbour 0x1B. A design that decodes too few bits there would skip ordinary arithmetic, while one that ignores the tag would stall on floating-point work. It drives the excluded load kinds and the destination field of the consumer, which a careless decoder might compare. It also drives back-to-back loads, a load to register 0, and a narrowed counter pushed past its ceiling. A design with those faults would drop pulses, stretch them, or wrap the count to zero.

// File: rtl/lui_pkg.sv
// Shared constants and types for the load-use interlock detector.
// Assumes the fixed 32-bit instruction layout with 5-bit register fields.
package lui_pkg;
    localparam int INSN_W  = 32;
    localparam int REG_AW  = 5;
    localparam int KIND_W  = 3;
    localparam int NSRC    = 2;
    localparam int FMT_HI  = 31;
    localparam int FMT_LO  = 30;
    localparam int OPF_HI  = 24;
    localparam int OPF_LO  = 20;
    localparam int RS1_HI  = 18;
    localparam int RS1_LO  = 14;
    localparam int IMM_BIT = 13;
    localparam int RS2_HI  = 4;
    localparam int RS2_LO  = 0;
    localparam int OPF_W   = OPF_HI - OPF_LO + 1;
    localparam logic [OPF_W-1:0] FPOP_TAG = 5'h1A;

    typedef enum logic [1:0] {
        FMT_BRANCH = 2'd0,
        FMT_CALL   = 2'd1,
        FMT_ALU    = 2'd2,
        FMT_MEM    = 2'd3
    } fmt_e;

    typedef enum logic [KIND_W-1:0] {
        LK_WORD   = 3'd0,
        LK_UBYTE  = 3'd1,
        LK_UHALF  = 3'd2,
        LK_SBYTE  = 3'd3,
        LK_SHALF  = 3'd4,
        LK_DOUBLE = 3'd5,
        LK_SWAP   = 3'd6,
        LK_TAS    = 3'd7
    } ld_kind_e;

    typedef struct packed {
        fmt_e              fmt;
        logic [OPF_W-1:0]  opf;
        logic [REG_AW-1:0] rs1;
        logic              imm;
        logic [REG_AW-1:0] rs2;
    } insn_fields_t;
endpackage

// File: rtl/lui_insn_fields.sv
// Splits a following instruction word into the fields the interlock rules need.
// Assumes field positions from lui_pkg; the remaining bits are not consulted.
module lui_insn_fields
    import lui_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output insn_fields_t      fields
);
    logic unused_bits;

    // Pick out format, operate tag, both source fields and the immediate flag.
    always_comb begin
        fields.fmt = fmt_e'(insn[FMT_HI:FMT_LO]);
        fields.opf = insn[OPF_HI:OPF_LO];
        fields.rs1 = insn[RS1_HI:RS1_LO];
        fields.imm = insn[IMM_BIT];
        fields.rs2 = insn[RS2_HI:RS2_LO];
    end

    assign unused_bits = ^{insn[29:25], insn[19], insn[12:5]};
endmodule

// File: rtl/lui_src_match.sv
// Decides whether the decoded following instruction reads a given register.
// Assumes fields come from lui_insn_fields; purely combinational.
module lui_src_match
    import lui_pkg::*;
(
    input  insn_fields_t      fields,
    input  logic [REG_AW-1:0] dest,
    output logic              hit
);
    logic                    reads_int;
    logic [REG_AW-1:0]       src [NSRC];
    logic [NSRC-1:0]         src_en;
    logic [NSRC-1:0]         src_eq;

    // Integer sources exist only for non-FP format-2 words and format-3 words.
    always_comb begin
        unique case (fields.fmt)
            FMT_ALU:  reads_int = (fields.opf != FPOP_TAG);
            FMT_MEM:  reads_int = 1'b1;
            default:  reads_int = 1'b0;
        endcase
    end

    // First source is always live; second only without an immediate.
    always_comb begin
        src[0]    = fields.rs1;
        src_en[0] = 1'b1;
        src[1]    = fields.rs2;
        src_en[1] = ~fields.imm;
    end

    for (genvar g = 0; g < NSRC; g++) begin : g_cmp
        assign src_eq[g] = src_en[g] && (src[g] == dest);
    end

    assign hit = reads_int && (|src_eq);
endmodule

// File: rtl/lui_kind_gate.sv
// Qualifies a load strobe by load kind: only single-register loads can interlock.
// Assumes the kind encoding of lui_pkg::ld_kind_e.
module lui_kind_gate
    import lui_pkg::*;
(
    input  logic              ld_valid,
    input  logic [KIND_W-1:0] ld_kind,
    output logic              qualified
);
    ld_kind_e kind;

    // Accept word and extended byte/half loads, reject the composite kinds.
    always_comb begin
        kind = ld_kind_e'(ld_kind);
        unique case (kind)
            LK_WORD, LK_UBYTE, LK_UHALF, LK_SBYTE, LK_SHALF: qualified = ld_valid;
            default:                                         qualified = 1'b0;
        endcase
    end
endmodule

// File: rtl/lui_sat_counter.sv
// Saturating event counter with synchronous active-low clear.
// Assumes at most one event per cycle.
module lui_sat_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] CMAX = '1;

    // Count events, stopping at the all-ones ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (inc && count != CMAX) count <= count + 1'b1;
    end
endmodule

// File: rtl/load_use_interlock.sv
// Load-use interlock detector top. On each qualifying load it checks whether
// the following word reads the load destination and pulses stall next cycle.
// Assumes next_insn is the word directly after the load, presented with ld_valid.
module load_use_interlock
    import lui_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic [KIND_W-1:0] ld_kind,
    input  logic [REG_AW-1:0] ld_dest,
    input  logic [INSN_W-1:0] next_insn,
    output logic              stall,
    output logic [CNT_W-1:0]  ilock_count
);
    insn_fields_t fields;
    logic         src_hit;
    logic         qualified;
    logic         detect;

    lui_insn_fields u_fields (
        .insn   (next_insn),
        .fields (fields)
    );

    lui_src_match u_match (
        .fields (fields),
        .dest   (ld_dest),
        .hit    (src_hit)
    );

    lui_kind_gate u_gate (
        .ld_valid  (ld_valid),
        .ld_kind   (ld_kind),
        .qualified (qualified)
    );

    assign detect = qualified && src_hit;

    // Register the detection into a single-cycle stall pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) stall <= 1'b0;
        else        stall <= detect;
    end

    lui_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (detect),
        .count (ilock_count)
    );
endmodule

// File: rtl/lui_checker.sv
// Property checker for load_use_interlock, attached by bind below.
// Assumes it sees the top's ports only.
module lui_checker #(
    parameter int CNT_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_valid,
    input logic [2:0]        ld_kind,
    input logic [4:0]        ld_dest,
    input logic [31:0]       next_insn,
    input logic              stall,
    input logic [CNT_W-1:0]  ilock_count
);
    a_r8_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ($past(ld_valid) && $past(rst_n)));

    a_r2_no_source_formats: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !next_insn[31]) |=> !stall);

    a_r7_excluded_kinds: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_kind >= 3'd5) |=> !stall);

    a_r3_fp_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        (next_insn[31:30] == 2'b10 && next_insn[24:20] == 5'h1A) |=> !stall);

    a_r9_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && stall && !(&$past(ilock_count)))
            |-> (ilock_count == $past(ilock_count) + 1'b1));

    a_r9_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !stall) |-> $stable(ilock_count));
endmodule

bind load_use_interlock lui_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ld_valid    (ld_valid),
    .ld_kind     (ld_kind),
    .ld_dest     (ld_dest),
    .next_insn   (next_insn),
    .stall       (stall),
    .ilock_count (ilock_count)
);

// File: tb/load_use_interlock_tb.sv
module load_use_interlock_tb;
    localparam int CW = 6;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_valid = 1'b0;
    logic [2:0]    ld_kind = 3'd0;
    logic [4:0]    ld_dest = 5'd0;
    logic [31:0]   next_insn = 32'd0;
    logic          stall;
    logic [CW-1:0] ilock_count;

    int  vectors = 0;
    int  errors = 0;
    int  exp_cnt = 0;
    bit  exp_q[$];
    bit  done = 1'b0;

    always #5 clk = ~clk;

    load_use_interlock #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_kind(ld_kind),
        .ld_dest(ld_dest), .next_insn(next_insn), .stall(stall),
        .ilock_count(ilock_count)
    );

    function automatic logic [31:0] mk(input logic [1:0] fmt, input logic [4:0] rd,
                                       input logic [4:0] opf, input logic [4:0] s1,
                                       input logic imm, input logic [4:0] s2);
        return {fmt, rd, opf, 1'b0, s1, imm, 8'h00, s2};
    endfunction

    // Behavioural model of the interlock rule.
    function automatic bit ref_hit(input bit v, input int kind, input int d, input logic [31:0] w);
        int f;
        if (!v || kind > 4) return 0;
        f = int'(w[31:30]);
        if (f < 2) return 0;
        if (f == 2 && int'(w[24:20]) == 26) return 0;
        if (int'(w[18:14]) == d) return 1;
        if (w[13]) return 0;
        return int'(w[4:0]) == d;
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(input bit v, input logic [2:0] k, input logic [4:0] d,
                        input logic [31:0] w, input string tag);
        bit e;
        ld_valid = v; ld_kind = k; ld_dest = d; next_insn = w;
        @(posedge clk);
        e = ref_hit(v, int'(k), int'(d), w);
        exp_q.push_back(e);
        if (e && exp_cnt < CMAX) exp_cnt++;
        @(negedge clk);
        chk(tag, int'(stall), int'(exp_q.pop_front()));
        chk(tag, int'(ilock_count), exp_cnt);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        ld_valid = 1'b1; ld_kind = 3'd0; ld_dest = 5'd3;
        next_insn = mk(2'b11, 5'd0, 5'd0, 5'd3, 1'b0, 5'd3);
        repeat (2) @(posedge clk);
        @(negedge clk);
        exp_cnt = 0;
        exp_q.delete();
        chk("R1 stall", int'(stall), 0);
        chk("R1 count", int'(ilock_count), 0);
        rst_n = 1'b1;
        ld_valid = 1'b0;
    endtask

    initial begin
        logic [31:0] lfsr;
        @(negedge clk);
        do_reset();
        // R2: branch/set-high and call formats
        step(1, 3'd0, 5'd7, mk(2'b00, 5'd7, 5'd7, 5'd7, 1'b0, 5'd7), "R2");
        step(1, 3'd0, 5'd7, mk(2'b01, 5'd7, 5'd7, 5'd7, 1'b0, 5'd7), "R2");
        // R3: FP tag skipped, neighbour tag checked
        step(1, 3'd0, 5'd9, mk(2'b10, 5'd0, 5'h1A, 5'd9, 1'b0, 5'd9), "R3");
        step(1, 3'd0, 5'd9, mk(2'b10, 5'd0, 5'h1B, 5'd9, 1'b0, 5'd1), "R3");
        step(1, 3'd0, 5'd9, mk(2'b11, 5'd0, 5'h1A, 5'd9, 1'b1, 5'd1), "R3");
        // R4: first source in both formats; destination field ignored
        step(1, 3'd0, 5'd12, mk(2'b10, 5'd0, 5'd0, 5'd12, 1'b1, 5'd0), "R4");
        step(1, 3'd0, 5'd12, mk(2'b11, 5'd0, 5'd4, 5'd12, 1'b0, 5'd0), "R4");
        step(1, 3'd0, 5'd12, mk(2'b11, 5'd12, 5'd4, 5'd1, 1'b0, 5'd2), "R4");
        // R5: immediate masks second source
        step(1, 3'd0, 5'd20, mk(2'b10, 5'd0, 5'd0, 5'd1, 1'b1, 5'd20), "R5");
        step(1, 3'd0, 5'd20, mk(2'b11, 5'd0, 5'd0, 5'd2, 1'b1, 5'd20), "R5");
        // R6: register second source
        step(1, 3'd0, 5'd20, mk(2'b10, 5'd0, 5'd0, 5'd1, 1'b0, 5'd20), "R6");
        step(1, 3'd0, 5'd20, mk(2'b11, 5'd0, 5'd0, 5'd1, 1'b0, 5'd21), "R6");
        // R7: every load kind
        for (int k = 0; k < 8; k++)
            step(1, 3'(k), 5'd5, mk(2'b11, 5'd0, 5'd0, 5'd5, 1'b0, 5'd5), "R7");
        // R8: no strobe, back-to-back pulses, then quiet
        step(0, 3'd0, 5'd5, mk(2'b11, 5'd0, 5'd0, 5'd5, 1'b0, 5'd5), "R8");
        step(1, 3'd1, 5'd5, mk(2'b10, 5'd0, 5'd0, 5'd5, 1'b0, 5'd5), "R8");
        step(1, 3'd3, 5'd6, mk(2'b10, 5'd0, 5'd0, 5'd0, 1'b0, 5'd6), "R8");
        step(0, 3'd0, 5'd0, 32'd0, "R8");
        // R10: register 0
        step(1, 3'd0, 5'd0, mk(2'b10, 5'd3, 5'd0, 5'd0, 1'b1, 5'd3), "R10");
        step(1, 3'd0, 5'd0, 32'h8000_0000, "R10");
        // Random sweep
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[7], lfsr[6:4], {lfsr[0], lfsr[3:0]} & 5'h13,
                 {lfsr[31:19], lfsr[18:14] & 5'h13, lfsr[13:5], lfsr[4:0] & 5'h13}, "R4");
        end
        // R1: reset mid-run, then R9 saturation
        do_reset();
        for (int i = 0; i < CMAX + 8; i++)
            step(1, 3'd2, 5'd17, mk(2'b11, 5'd0, 5'd0, 5'd17, 1'b1, 5'd0), "R9");
        step(0, 3'd0, 5'd0, 32'd0, "R9");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule